// File: doc/BRIEF.md
# Memory Boundary Scan Data Register

This block is the boundary scan data register of a synchronous memory device. It has one cell for each position of the device's pin ring, whether input or output. It also has placeholder cells for unconnected pins, which keep the cell ordering fixed so that larger devices in the same family can use the same chain. The test access port state machine sits outside the block and drives it with per-state strobes (Capture-DR, Shift-DR, Update-DR). The instruction decode also sits outside and supplies a two-bit mode.

On a capture strobe every cell loads the present value of its ring position. On a shift strobe the chain moves one bit per rising TCK edge, from TDI toward TDO. On an update strobe an update latch takes a copy of the shift stage. In external-test mode the output pads are driven from that latch. In the float mode the ring is sampled while every output enable is withdrawn. The order of the cells is a parameter: each cell is described by one byte holding a kind and a pin index.

Top module: `mem_bscan_reg`

## Requirements
- R1: While trstN is low, tdo and tdoEn are 0, the shift stage is cleared and the update latch is cleared. After reset, selecting external-test mode drives all output pads to 0.
- R2: When captureDr is high at a rising TCK edge in any mode other than off, each cell loads its ring value. An input cell loads pinIn[idx] and an output cell loads padOut[idx]. The cell byte is laid out as kind in bits 7:6 (0 unconnected, 1 input, 2 output) and idx in bits 5:0.
- R3: When shiftDr is high at a rising edge in a selected mode, the chain shifts once. Cell 0 is nearest TDO and leaves first. TDI enters at the last cell, so after N shifts the first TDI bit sits in cell 0.
- R4: tdo and tdoEn change only on the falling edge of TCK. tdo shows cell 0 of the shift stage. tdoEn is high only while shiftDr is high in a selected mode.
- R5: The update latch loads the shift stage on the falling TCK edge while updateDr is high in a selected mode. It holds its value through capture and shift.
- R6: In external-test mode (mode 2), each output pad takes the update latch bit of its cell and every pad enable is 1.
- R7: In sample/preload mode (mode 1) and in off mode (mode 0), padOut equals coreOut and padOe equals coreOe. A preload through shift and update does not disturb the pads.
- R8: In float mode (mode 3), every padOe bit is 0. Capture and shift still work, and output cells capture the core's output value.
- R9: In off mode (mode 0), all three strobes are ignored. The shift stage and the latch keep their contents and tdoEn stays 0.
- R10: Unconnected cells capture 0 regardless of the pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| mode | input | 2 | 0 off, 1 sample/preload, 2 external test, 3 float |
| captureDr | input | 1 | Capture-DR state strobe |
| shiftDr | input | 1 | Shift-DR state strobe |
| updateDr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdoEn | output | 1 | Output enable for tdo |
| pinIn | input | NUM_IN | Values at the input pads |
| coreOut | input | NUM_OUT | Output data from the memory core |
| coreOe | input | NUM_OUT | Output enables from the memory core |
| padOut | output | NUM_OUT | Data toward the output pads |
| padOe | output | NUM_OUT | Enables toward the output pads |

## Verification
Capture and scan-out are swept over every combination of input-pin and core-output values in the small default chain. This tells apart cells placed in the wrong position, pins swapped between kinds, and unconnected cells that leak a pin value. A double-length scan with a fixed TDI pattern separates the direction of the chain from its length. All eight latch patterns are preloaded and then applied under external test, which tests the output mapping of the latch and its hold behaviour through later shifts. Separate patterns cover the float mode, the falling-edge timing of TDO, and the off mode, where the strobes must leave the chain and the latch untouched.

// File: rtl/mem_bscan_pkg.sv
package mem_bscan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_EXTEST = 2'd2,
    MODE_FLOAT  = 2'd3
  } bsrModeE;

  localparam logic [1:0] KIND_NC  = 2'd0;
  localparam logic [1:0] KIND_IN  = 2'd1;
  localparam logic [1:0] KIND_OUT = 2'd2;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic fromLatch;
    logic floatOut;
    logic tdoActive;
  } bsrCtrlS;

endpackage

// File: rtl/mem_bscan_ctrl.sv
module mem_bscan_ctrl
  import mem_bscan_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  output bsrCtrlS    ctrl
);

  bsrModeE modeE;
  logic    selected;

  assign modeE    = bsrModeE'(mode);
  assign selected = (modeE != MODE_OFF);

  always_comb begin
    ctrl           = '0;
    ctrl.capture   = selected & captureDr;
    ctrl.shift     = selected & shiftDr & ~captureDr;
    ctrl.update    = selected & updateDr;
    ctrl.tdoActive = selected & shiftDr;
    ctrl.fromLatch = (modeE == MODE_EXTEST);
    ctrl.floatOut  = (modeE == MODE_FLOAT);
  end

endmodule

// File: rtl/mem_bscan_dp.sv
module mem_bscan_dp
  import mem_bscan_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 3,
  parameter int NUM_CELLS = 9,
  parameter logic [8*NUM_CELLS-1:0] CELL_LIST = '0
) (
  input  logic               tck,
  input  logic               trstN,
  input  bsrCtrlS            ctrl,
  input  logic               tdi,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic               tdo,
  output logic               tdoEn,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe
);

  localparam int ENTRY_W = 8;

  logic [NUM_CELLS-1:0] shiftQ;
  logic [NUM_CELLS-1:0] latchQ;
  logic [NUM_CELLS-1:0] capVal;

  // position in the chain of the cell that owns output pin outIdx
  function automatic int cellOfOut(input int outIdx);
    int found;
    found = 0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (CELL_LIST[ENTRY_W*c+6 +: 2] == KIND_OUT &&
          int'(CELL_LIST[ENTRY_W*c +: 6]) == outIdx)
        found = c;
    end
    return found;
  endfunction

  // capture source of every cell, chosen by its kind
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam logic [1:0] KIND = CELL_LIST[ENTRY_W*i+6 +: 2];
    localparam int         IDX  = int'(CELL_LIST[ENTRY_W*i +: 6]);
    if (KIND == KIND_IN) begin : g_in
      assign capVal[i] = pinIn[IDX];
    end else if (KIND == KIND_OUT) begin : g_out
      assign capVal[i] = padOut[IDX];
    end else begin : g_nc
      assign capVal[i] = 1'b0;
    end
  end

  // shift stage: rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      shiftQ <= '0;
    end else if (ctrl.capture) begin
      shiftQ <= capVal;
    end else if (ctrl.shift) begin
      shiftQ <= {tdi, shiftQ[NUM_CELLS-1:1]};
    end
  end

  // update latch and serial output: falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      latchQ <= '0;
      tdo    <= 1'b0;
      tdoEn  <= 1'b0;
    end else begin
      if (ctrl.update) latchQ <= shiftQ;
      tdo   <= shiftQ[0];
      tdoEn <= ctrl.tdoActive;
    end
  end

  // output pad multiplexers
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_pad
    localparam int CELL = cellOfOut(j);
    assign padOut[j] = ctrl.fromLatch ? latchQ[CELL] : coreOut[j];
    assign padOe[j]  = ctrl.floatOut  ? 1'b0 :
                       ctrl.fromLatch ? 1'b1 : coreOe[j];
  end

endmodule

// File: rtl/mem_bscan_reg.sv
module mem_bscan_reg
  import mem_bscan_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int NUM_OUT   = 3,
  parameter int NUM_CELLS = 9,
  // one byte per cell, cell 0 nearest tdo: {kind[1:0], idx[5:0]}
  parameter logic [8*NUM_CELLS-1:0] CELL_LIST = 72'h82_00_43_81_42_00_80_41_40
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic [1:0]         mode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoEn,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe
);

  bsrCtrlS ctrl;

  mem_bscan_ctrl u_ctrl (
    .mode      (mode),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .ctrl      (ctrl)
  );

  mem_bscan_dp #(
    .NUM_IN    (NUM_IN),
    .NUM_OUT   (NUM_OUT),
    .NUM_CELLS (NUM_CELLS),
    .CELL_LIST (CELL_LIST)
  ) u_dp (
    .tck     (tck),
    .trstN   (trstN),
    .ctrl    (ctrl),
    .tdi     (tdi),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .tdo     (tdo),
    .tdoEn   (tdoEn),
    .padOut  (padOut),
    .padOe   (padOe)
  );

endmodule

// File: rtl/mem_bscan_reg_chk.sv
module mem_bscan_reg_chk #(
  parameter int NUM_OUT = 3
) (
  input logic               tck,
  input logic               trstN,
  input logic [1:0]         mode,
  input logic               shiftDr,
  input logic               updateDr,
  input logic               tdoEn,
  input logic [NUM_OUT-1:0] coreOut,
  input logic [NUM_OUT-1:0] coreOe,
  input logic [NUM_OUT-1:0] padOut,
  input logic [NUM_OUT-1:0] padOe
);

  a_r8_float_outputs: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd3) |-> (padOe == '0));

  a_r6_extest_enables: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd2) |-> (&padOe));

  a_r7_sample_follows_core: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd1) |-> (padOut == coreOut && padOe == coreOe));

  a_r5_latch_holds: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd2 && $past(mode) == 2'd2 && !updateDr) |-> $stable(padOut));

  a_r4_tdo_enable: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (shiftDr && mode != 2'd0));

endmodule

bind mem_bscan_reg mem_bscan_reg_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .tck      (tck),
  .trstN    (trstN),
  .mode     (mode),
  .shiftDr  (shiftDr),
  .updateDr (updateDr),
  .tdoEn    (tdoEn),
  .coreOut  (coreOut),
  .coreOe   (coreOe),
  .padOut   (padOut),
  .padOe    (padOe)
);

// File: tb/sim_mem_bscan_reg.sv
`timescale 1ns/1ps
module sim_mem_bscan_reg;

  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NC = 9;
  localparam logic [8*NC-1:0] LIST = 72'h82_00_43_81_42_00_80_41_40;

  logic          tck = 1'b0;
  logic          trstN = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic          tdo, tdoEn;
  logic [NI-1:0] pinIn = '0;
  logic [NO-1:0] coreOut = '0, coreOe = '0;
  logic [NO-1:0] padOut, padOe;

  int nRun = 0;
  int nFail = 0;

  mem_bscan_reg #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_CELLS(NC), .CELL_LIST(LIST)) u0 (
    .tck(tck), .trstN(trstN), .mode(mode), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .pinIn(pinIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe));

  always #4 tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected capture vector from the cell list
  function automatic logic [31:0] expCap(input logic [NI-1:0] p, input logic [NO-1:0] c);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < NC; i++) begin
      if (LIST[8*i+6 +: 2] == 2'd1) v[i] = p[LIST[8*i +: 6]];
      else if (LIST[8*i+6 +: 2] == 2'd2) v[i] = c[LIST[8*i +: 6]];
    end
    return v;
  endfunction

  // shift vector that places bit o of v into the cell of output o
  function automatic logic [31:0] preloadVec(input logic [NO-1:0] v);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NC; i++)
      if (LIST[8*i+6 +: 2] == 2'd2) s[i] = v[LIST[8*i +: 6]];
    return s;
  endfunction

  // every task starts and ends 1 ns after a rising edge
  task automatic doCapture();
    captureDr = 1'b1;
    @(posedge tck) #1;
    captureDr = 1'b0;
  endtask

  task automatic doUpdate();
    updateDr = 1'b1;
    @(negedge tck) #1;
    @(posedge tck) #1;
    updateDr = 1'b0;
  endtask

  task automatic scan(input int n, input logic [31:0] tdiBits,
                      output logic [31:0] got, output int enCount);
    got = '0;
    enCount = 0;
    shiftDr = 1'b1;
    for (int k = 0; k < n; k++) begin
      tdi = tdiBits[k];
      @(negedge tck) #1;
      got[k] = tdo;
      if (tdoEn) enCount++;
      @(posedge tck) #1;
    end
    shiftDr = 1'b0;
    tdi = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [31:0] held;
    int en;
    logic v0;

    // R1: reset state
    repeat (3) @(posedge tck);
    #1;
    check(tdo == 1'b0 && tdoEn == 1'b0, "R1 tdo/tdoEn in reset", {tdo, tdoEn}, 0);
    trstN = 1'b1;
    @(posedge tck) #1;
    mode = 2'd2;
    #1;
    check(padOut == '0, "R1 latch cleared", padOut, 0);
    check(padOe == '1, "R6 enables in external test", padOe, 7);

    // R2 R7 R4: full sweep in sample mode
    mode = 2'd1;
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 8; c++) begin
        pinIn = NI'(p);
        coreOut = NO'(c);
        coreOe = NO'(c) ^ 3'b101;
        #1;
        check(padOut == NO'(c) && padOe == (NO'(c) ^ 3'b101), "R7 pads follow core",
              {padOe, padOut}, {NO'(c) ^ 3'b101, NO'(c)});
        doCapture();
        scan(NC, '0, got, en);
        check(got == expCap(NI'(p), NO'(c)), "R2 captured ring", got, expCap(NI'(p), NO'(c)));
        check(en == NC, "R4 tdoEn during shift", en, NC);
      end
    end

    // R10: unconnected cells with every pin high
    pinIn = '1;
    coreOut = '1;
    doCapture();
    scan(NC, '0, got, en);
    check(got[3] == 1'b0 && got[7] == 1'b0, "R10 unconnected cells zero", {got[7], got[3]}, 0);

    // R3: double-length scan
    pinIn = 4'hA;
    coreOut = 3'h5;
    doCapture();
    scan(2 * NC, 32'h1B3, got, en);
    check(got[8:0] == expCap(4'hA, 3'h5), "R3 first pass is capture", got[8:0], expCap(4'hA, 3'h5));
    check(got[17:9] == 9'h1B3, "R3 tdi order", got[17:9], 9'h1B3);

    // R4: tdo changes only on the falling edge
    pinIn = 4'h1;
    doCapture();
    shiftDr = 1'b1;
    @(negedge tck) #1;
    v0 = tdo;
    check(v0 == 1'b1, "R4 first bit cell 0", v0, 1);
    @(posedge tck) #1;
    check(tdo == v0, "R4 tdo stable across rising edge", tdo, v0);
    @(negedge tck) #1;
    check(tdo == 1'b0, "R4 second bit cell 1", tdo, 0);
    @(posedge tck) #1;
    shiftDr = 1'b0;
    @(negedge tck) #1;
    check(tdoEn == 1'b0, "R4 tdoEn drops after shift", tdoEn, 0);
    @(posedge tck) #1;

    // R5 R6 R7: preload every latch pattern
    coreOut = '0;
    coreOe = '0;
    for (int v = 0; v < 8; v++) begin
      mode = 2'd1;
      scan(NC, preloadVec(NO'(v)), got, en);
      doUpdate();
      check(padOut == '0 && padOe == '0, "R7 preload leaves pads", {padOe, padOut}, 0);
      mode = 2'd2;
      #1;
      check(padOut == NO'(v) && padOe == '1, "R6 latch drives pads", {padOe, padOut}, {3'b111, NO'(v)});
      scan(NC, ~preloadVec(NO'(v)), got, en);
      doCapture();
      check(padOut == NO'(v), "R5 latch holds through shift/capture", padOut, NO'(v));
    end

    // R8: float mode
    mode = 2'd3;
    coreOe = '1;
    coreOut = 3'h5;
    pinIn = 4'h6;
    #1;
    check(padOe == '0, "R8 enables withdrawn", padOe, 0);
    doCapture();
    scan(NC, '0, got, en);
    check(got == expCap(4'h6, 3'h5), "R8 capture while floating", got, expCap(4'h6, 3'h5));

    // R9: off mode ignores strobes
    mode = 2'd1;
    pinIn = 4'h3;
    coreOut = 3'h2;
    doCapture();
    held = expCap(4'h3, 3'h2);
    mode = 2'd0;
    pinIn = 4'hC;
    coreOut = 3'h5;
    doCapture();
    scan(NC, '1, got, en);
    check(en == 0, "R9 tdoEn stays low", en, 0);
    doUpdate();
    mode = 2'd1;
    scan(NC, '0, got, en);
    check(got[8:0] == held[8:0], "R9 shift stage kept", got, held);
    mode = 2'd2;
    #1;
    check(padOut == 3'h7, "R9 latch kept", padOut, 7);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule